// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Flag Register and Stack Pointer

This block is the arithmetic core of a small 8-bit processor. It holds two accumulators, A and B. Each operation takes its first operand from a destination accumulator and its second operand from the other one, and writes the result back to the destination. Each result also updates an 8-bit flag register. The unit supports load, add, add-with-carry, subtract, AND, OR, XOR, increment and decrement. Flag bits 5..0 are, from bit 0 upward: carry, overflow, zero, negative, interrupt mask and half-carry. Bits 7 and 6 always read as 1.

A 16-bit stack pointer saves accumulators to memory and restores them, one byte per cycle. The pointer always addresses the next free location. A push stores the byte at the pointer and then moves the pointer down. A pop moves the pointer up and reads from the new position. Stack memory is outside the block. The block drives the address, the write strobe and the write data, and the memory returns read data in the same cycle.

Flags can also be loaded directly, and the interrupt mask can be set or cleared on its own. The block has no instruction decoder. A controller drives the operation code and the strobes every cycle.

Top module: `acc_alu_top`

## Requirements
- R1: After reset both accumulators read 0x00, the flag register reads 0xD0 (mask set, top two bits 1) and the stack pointer reads SP_INIT (0x01FF).
- R2: Add (op_code 2) and add-with-carry (op_code 3) write dst+other (+carry for 3) to the destination. They set carry (bit 0) from the carry out of bit 7 and half-carry (bit 5) from the carry out of bit 3.
- R3: Overflow (bit 1) is set on add when both operands share a sign that the result does not. On subtract it is set when the operand signs differ and the result sign differs from the destination operand.
- R4: Every result-producing arithmetic or logic operation sets negative (bit 3) to result bit 7 and zero (bit 2) when the result is 0x00.
- R5: Subtract (op_code 4) writes dst-other. It sets carry when a borrow occurs and leaves half-carry unchanged.
- R6: AND (5), OR (6) and XOR (7) clear overflow and leave carry and half-carry unchanged.
- R7: Increment (8) and decrement (9) leave carry and half-carry unchanged. They set overflow only on 0x7F to 0x80 (increment) or 0x80 to 0x7F (decrement).
- R8: Flag bits 7 and 6 read 1 whatever value is written to the flag register.
- R9: mask_set sets bit 4 and mask_clr clears it, with set winning when both are asserted. A flag-register write in the same cycle overrides both the operation's flags and the mask strobes.
- R10: A push drives stk_addr = sp, stk_we = 1 and stk_wdata = the accumulator chosen by stk_sel (0 = A, 1 = B). The pointer then decrements.
- R11: A pop drives stk_addr = sp+1 and increments the pointer. It loads stk_rdata into the chosen accumulator, and it wins over an operation result aimed at the same accumulator.
- R12: Load (op_code 1) writes op_data to the destination (op_dst 0 = A, 1 = B) and leaves all flags unchanged. op_code 0 does nothing.
- R13: Push and pop in the same cycle do nothing: no write strobe, no pointer move and no accumulator load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation code |
| op_dst | input | 1 | Destination accumulator, 0 = A, 1 = B |
| op_data | input | 8 | Value for the load operation |
| ccr_wr | input | 1 | Flag register write strobe |
| ccr_wdata | input | 8 | Flag register write value |
| mask_set | input | 1 | Set the interrupt mask |
| mask_clr | input | 1 | Clear the interrupt mask |
| push | input | 1 | Push request |
| pop | input | 1 | Pop request |
| stk_sel | input | 1 | Accumulator for push or pop, 0 = A, 1 = B |
| stk_rdata | input | 8 | Stack read data, valid in the cycle of the pop |
| acc_a | output | 8 | Accumulator A |
| acc_b | output | 8 | Accumulator B |
| ccr | output | 8 | Flag register |
| sp | output | 16 | Stack pointer |
| stk_addr | output | 16 | Stack memory address |
| stk_we | output | 1 | Stack memory write strobe |
| stk_wdata | output | 8 | Stack memory write data |

## Verification
Two updates can land on the flag register in the same cycle: the flags from an arithmetic result and a direct register write. The bench issues an add that would set carry, zero and half-carry while also writing 0x01 to the flags. It expects 0x01 with the top bits forced, and the sum still stored. A pop and an arithmetic result aimed at the same accumulator also collide. There the bench expects the popped byte to stand and the pointer to rise by one.

// File: rtl/acc_alu_pkg.sv
// Package: operation codes and flag bit positions shared by the unit.
package acc_alu_pkg;
    typedef enum logic [3:0] {
        OP_NOP = 4'd0,
        OP_LD  = 4'd1,
        OP_ADD = 4'd2,
        OP_ADC = 4'd3,
        OP_SUB = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7,
        OP_INC = 4'd8,
        OP_DEC = 4'd9
    } alu_op_e;

    localparam int FL_C = 0;
    localparam int FL_V = 1;
    localparam int FL_Z = 2;
    localparam int FL_N = 3;
    localparam int FL_I = 4;
    localparam int FL_H = 5;
    localparam int FL_W = 6;
endpackage

// File: rtl/acc_alu_func.sv
// Combinational function unit: computes the result and the next flags (bits 5..0)
// for one operation. Assumes the caller gates it with op_valid.
module acc_alu_func
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] load_val,
    input  logic [FL_W-1:0]   fl_in,
    output logic [DATA_W-1:0] res,
    output logic [FL_W-1:0]   fl_out,
    output logic              wr_res,
    output logic              wr_fl
);
    localparam int MSB = DATA_W - 1;
    localparam int HB  = DATA_W / 2;

    logic              cin;
    logic [DATA_W:0]   sum;
    logic [HB:0]       hsum;
    logic [DATA_W:0]   diff;
    logic [DATA_W-1:0] one;

    // Shared adder and subtractor with carry-in only for add-with-carry.
    always_comb begin
        one  = {{(DATA_W-1){1'b0}}, 1'b1};
        cin  = (op == OP_ADC) ? fl_in[FL_C] : 1'b0;
        sum  = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, cin};
        hsum = {1'b0, opa[HB-1:0]} + {1'b0, opb[HB-1:0]} + {{HB{1'b0}}, cin};
        diff = {1'b0, opa} - {1'b0, opb};
    end

    // Result and flag selection by operation.
    always_comb begin
        res    = opa;
        fl_out = fl_in;
        wr_res = 1'b1;
        wr_fl  = 1'b1;
        case (op)
            OP_LD: begin
                res   = load_val;
                wr_fl = 1'b0;
            end
            OP_ADD, OP_ADC: begin
                res          = sum[DATA_W-1:0];
                fl_out[FL_C] = sum[DATA_W];
                fl_out[FL_H] = hsum[HB];
                fl_out[FL_V] = (opa[MSB] == opb[MSB]) && (res[MSB] != opa[MSB]);
            end
            OP_SUB: begin
                res          = diff[DATA_W-1:0];
                fl_out[FL_C] = diff[DATA_W];
                fl_out[FL_V] = (opa[MSB] != opb[MSB]) && (res[MSB] != opa[MSB]);
            end
            OP_AND, OP_OR, OP_XOR: begin
                res          = (op == OP_AND) ? (opa & opb) :
                               (op == OP_OR)  ? (opa | opb) : (opa ^ opb);
                fl_out[FL_V] = 1'b0;
            end
            OP_INC: begin
                res          = opa + one;
                fl_out[FL_V] = ~opa[MSB] & res[MSB];
            end
            OP_DEC: begin
                res          = opa - one;
                fl_out[FL_V] = opa[MSB] & ~res[MSB];
            end
            default: begin
                wr_res = 1'b0;
                wr_fl  = 1'b0;
            end
        endcase
        if (wr_fl) begin
            fl_out[FL_N] = res[MSB];
            fl_out[FL_Z] = (res == '0);
        end
    end
endmodule

// File: rtl/acc_alu_ccr.sv
// Flag register: takes operation flags, mask strobes and direct writes.
// A direct write overrides everything in its cycle. Bits 7..6 are constant 1.
module acc_alu_ccr
    import acc_alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fl_upd,
    input  logic [FL_W-1:0] fl_new,
    input  logic            wr,
    input  logic [7:0]      wdata,
    input  logic            mask_set,
    input  logic            mask_clr,
    output logic [7:0]      ccr
);
    logic [FL_W-1:0] q;
    logic [FL_W-1:0] nxt;

    // Merge the update sources by priority.
    always_comb begin
        nxt = q;
        if (fl_upd) nxt = fl_new;
        if (mask_set)      nxt[FL_I] = 1'b1;
        else if (mask_clr) nxt[FL_I] = 1'b0;
        if (wr) nxt = wdata[FL_W-1:0];
    end

    // Flag storage; reset leaves the mask set.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 6'b010000;
        else        q <= nxt;
    end

    assign ccr = {2'b11, q};

    // R9
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_set && !wr) |=> ccr[FL_I]);
    // R9
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_clr && !mask_set && !wr) |=> !ccr[FL_I]);
    // R8
    ccr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (ccr == ($past(wdata) | 8'hC0)));
endmodule

// File: rtl/acc_alu_stack.sv
// Stack pointer: points at the next free byte. Push writes then decrements,
// pop increments then reads. Push with pop in one cycle is dropped.
module acc_alu_stack #(
    parameter int            SP_W    = 16,
    parameter logic [SP_W-1:0] SP_INIT = 16'h01FF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    output logic [SP_W-1:0] sp,
    output logic [SP_W-1:0] addr,
    output logic            we,
    output logic            pop_fire
);
    logic push_fire;

    assign push_fire = push & ~pop;
    assign pop_fire  = pop & ~push;
    assign we        = push_fire;
    assign addr      = pop_fire ? sp + 1'b1 : sp;

    // Pointer movement.
    always_ff @(posedge clk) begin
        if (!rst_n)         sp <= SP_INIT;
        else if (push_fire) sp <= sp - 1'b1;
        else if (pop_fire)  sp <= sp + 1'b1;
    end

    // R10
    push_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (sp == $past(addr) - 1'b1));
    // R11
    pop_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (sp == $past(addr)));
    // R13
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(sp));
endmodule

// File: rtl/acc_alu_top.sv
// Top: two accumulators around the function unit, the flag register and the
// stack pointer. Operand 1 is the destination accumulator, operand 2 the other.
module acc_alu_top
    import acc_alu_pkg::*;
#(
    parameter int              DATA_W  = 8,
    parameter int              SP_W    = 16,
    parameter logic [SP_W-1:0] SP_INIT = 16'h01FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic              op_dst,
    input  logic [DATA_W-1:0] op_data,
    input  logic              ccr_wr,
    input  logic [7:0]        ccr_wdata,
    input  logic              mask_set,
    input  logic              mask_clr,
    input  logic              push,
    input  logic              pop,
    input  logic              stk_sel,
    input  logic [DATA_W-1:0] stk_rdata,
    output logic [DATA_W-1:0] acc_a,
    output logic [DATA_W-1:0] acc_b,
    output logic [7:0]        ccr,
    output logic [SP_W-1:0]   sp,
    output logic [SP_W-1:0]   stk_addr,
    output logic              stk_we,
    output logic [DATA_W-1:0] stk_wdata
);
    localparam int N_ACC = 2;

    logic [DATA_W-1:0] acc_q [N_ACC];
    logic [DATA_W-1:0] res;
    logic [FL_W-1:0]   fl_new;
    logic              wr_res, wr_fl, pop_fire;
    alu_op_e           op;

    assign op = op_valid ? alu_op_e'(op_code) : OP_NOP;

    acc_alu_func #(.DATA_W(DATA_W)) u_func (
        .op(op), .opa(acc_q[op_dst]), .opb(acc_q[~op_dst]), .load_val(op_data),
        .fl_in(ccr[FL_W-1:0]), .res(res), .fl_out(fl_new),
        .wr_res(wr_res), .wr_fl(wr_fl)
    );

    acc_alu_ccr u_ccr (
        .clk(clk), .rst_n(rst_n), .fl_upd(wr_fl), .fl_new(fl_new),
        .wr(ccr_wr), .wdata(ccr_wdata), .mask_set(mask_set),
        .mask_clr(mask_clr), .ccr(ccr)
    );

    acc_alu_stack #(.SP_W(SP_W), .SP_INIT(SP_INIT)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .sp(sp),
        .addr(stk_addr), .we(stk_we), .pop_fire(pop_fire)
    );

    assign stk_wdata = acc_q[stk_sel];

    // One register per accumulator; a pop overrides an operation result.
    for (genvar g = 0; g < N_ACC; g++) begin : g_acc
        always_ff @(posedge clk) begin
            if (!rst_n)
                acc_q[g] <= '0;
            else if (pop_fire && (stk_sel == 1'(g)))
                acc_q[g] <= stk_rdata;
            else if (wr_res && (op_dst == 1'(g)))
                acc_q[g] <= res;
        end
    end

    assign acc_a = acc_q[0];
    assign acc_b = acc_q[1];

    // R6
    logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !ccr_wr && (op_code inside {4'd5, 4'd6, 4'd7}))
        |=> (ccr[FL_C] == $past(ccr[FL_C])) && !ccr[FL_V]);
    // R7
    incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !ccr_wr && (op_code inside {4'd8, 4'd9}))
        |=> (ccr[FL_C] == $past(ccr[FL_C])));
    // R11
    pop_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !stk_sel) |=> (acc_a == $past(stk_rdata)));
endmodule

// File: tb/test_acc_alu_top.sv
module test_acc_alu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic        op_dst = 1'b0;
    logic [7:0]  op_data = 8'h00;
    logic        ccr_wr = 1'b0;
    logic [7:0]  ccr_wdata = 8'h00;
    logic        mask_set = 1'b0, mask_clr = 1'b0;
    logic        push = 1'b0, pop = 1'b0, stk_sel = 1'b0;
    logic [7:0]  stk_rdata;
    logic [7:0]  acc_a, acc_b, ccr, stk_wdata;
    logic [15:0] sp, stk_addr;
    logic        stk_we;
    logic [7:0]  mem [16];
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    acc_alu_top i_acc_alu_top (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_dst(op_dst), .op_data(op_data), .ccr_wr(ccr_wr),
        .ccr_wdata(ccr_wdata), .mask_set(mask_set), .mask_clr(mask_clr),
        .push(push), .pop(pop), .stk_sel(stk_sel), .stk_rdata(stk_rdata),
        .acc_a(acc_a), .acc_b(acc_b), .ccr(ccr), .sp(sp),
        .stk_addr(stk_addr), .stk_we(stk_we), .stk_wdata(stk_wdata)
    );

    assign stk_rdata = mem[stk_addr[3:0]];
    always @(posedge clk) if (stk_we) mem[stk_addr[3:0]] <= stk_wdata;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        op_valid = 0; ccr_wr = 0; mask_set = 0; mask_clr = 0; push = 0; pop = 0;
    endtask

    task automatic run_op(input logic [3:0] code, input logic dst, input logic [7:0] d);
        @(negedge clk);
        op_valid = 1; op_code = code; op_dst = dst; op_data = d;
        @(negedge clk);
        idle();
    endtask

    task automatic wr_ccr(input logic [7:0] v);
        @(negedge clk);
        ccr_wr = 1; ccr_wdata = v;
        @(negedge clk);
        idle();
    endtask

    task automatic setup(input logic [7:0] a, input logic [7:0] b, input logic [7:0] f);
        run_op(4'd1, 1'b0, a);
        run_op(4'd1, 1'b1, b);
        wr_ccr(f);
    endtask

    task automatic t_reset();
        chk("R1 acc_a", {8'h0, acc_a}, 16'h0000);
        chk("R1 acc_b", {8'h0, acc_b}, 16'h0000);
        chk("R1 ccr", {8'h0, ccr}, 16'h00D0);
        chk("R1 sp", sp, 16'h01FF);
    endtask

    task automatic t_add();
        setup(8'h3A, 8'h48, 8'hD0);
        run_op(4'd2, 1'b0, 8'h00);
        chk("R2 add result", {8'h0, acc_a}, 16'h0082);
        chk("R3 add overflow flags", {8'h0, ccr}, 16'h00FA);
        setup(8'hFF, 8'h01, 8'hD0);
        run_op(4'd2, 1'b0, 8'h00);
        chk("R2 add wrap", {8'h0, acc_a}, 16'h0000);
        chk("R4 add carry zero flags", {8'h0, ccr}, 16'h00F5);
        setup(8'h10, 8'h20, 8'hC1);
        run_op(4'd3, 1'b0, 8'h00);
        chk("R2 adc result", {8'h0, acc_a}, 16'h0031);
        chk("R2 adc flags", {8'h0, ccr}, 16'h00C0);
    endtask

    task automatic t_sub();
        setup(8'h10, 8'h20, 8'hE0);
        run_op(4'd4, 1'b0, 8'h00);
        chk("R5 sub result", {8'h0, acc_a}, 16'h00F0);
        chk("R5 sub borrow keeps H", {8'h0, ccr}, 16'h00E9);
        setup(8'h01, 8'h80, 8'hC0);
        run_op(4'd4, 1'b1, 8'h00);
        chk("R3 sub into B", {8'h0, acc_b}, 16'h007F);
        chk("R3 sub overflow", {8'h0, ccr}, 16'h00C2);
    endtask

    task automatic t_logic();
        setup(8'hF0, 8'h0F, 8'hE3);
        run_op(4'd5, 1'b0, 8'h00);
        chk("R6 and result", {8'h0, acc_a}, 16'h0000);
        chk("R6 and flags", {8'h0, ccr}, 16'h00E5);
        setup(8'h80, 8'h01, 8'hE3);
        run_op(4'd6, 1'b0, 8'h00);
        chk("R6 or result", {8'h0, acc_a}, 16'h0081);
        chk("R6 or flags", {8'h0, ccr}, 16'h00E9);
        setup(8'hFF, 8'h0F, 8'hC2);
        run_op(4'd7, 1'b0, 8'h00);
        chk("R4 xor result", {8'h0, acc_a}, 16'h00F0);
        chk("R4 xor flags", {8'h0, ccr}, 16'h00C8);
    endtask

    task automatic t_incdec();
        setup(8'h7F, 8'h00, 8'hC1);
        run_op(4'd8, 1'b0, 8'h00);
        chk("R7 inc result", {8'h0, acc_a}, 16'h0080);
        chk("R7 inc overflow", {8'h0, ccr}, 16'h00CB);
        wr_ccr(8'hC1);
        run_op(4'd9, 1'b0, 8'h00);
        chk("R7 dec result", {8'h0, acc_a}, 16'h007F);
        chk("R7 dec overflow", {8'h0, ccr}, 16'h00C3);
        setup(8'hFF, 8'h00, 8'hC0);
        run_op(4'd8, 1'b0, 8'h00);
        chk("R7 inc wrap result", {8'h0, acc_a}, 16'h0000);
        chk("R7 inc wrap no carry", {8'h0, ccr}, 16'h00C4);
    endtask

    task automatic t_ccr();
        wr_ccr(8'h00);
        chk("R8 top bits forced", {8'h0, ccr}, 16'h00C0);
        @(negedge clk); mask_set = 1; @(negedge clk); idle();
        chk("R9 mask set", {8'h0, ccr}, 16'h00D0);
        @(negedge clk); mask_clr = 1; @(negedge clk); idle();
        chk("R9 mask clear", {8'h0, ccr}, 16'h00C0);
        @(negedge clk); mask_clr = 1; mask_set = 1; @(negedge clk); idle();
        chk("R9 set beats clear", {8'h0, ccr}, 16'h00D0);
        setup(8'hFF, 8'h01, 8'hC0);
        @(negedge clk);
        op_valid = 1; op_code = 4'd2; op_dst = 0; ccr_wr = 1; ccr_wdata = 8'h01;
        mask_set = 1;
        @(negedge clk); idle();
        chk("R9 write beats add flags", {8'h0, ccr}, 16'h00C1);
        chk("R9 add result kept", {8'h0, acc_a}, 16'h0000);
        wr_ccr(8'hE5);
        run_op(4'd1, 1'b1, 8'h99);
        chk("R12 load value", {8'h0, acc_b}, 16'h0099);
        chk("R12 load keeps flags", {8'h0, ccr}, 16'h00E5);
        run_op(4'd0, 1'b1, 8'h11);
        chk("R12 nop keeps B", {8'h0, acc_b}, 16'h0099);
    endtask

    task automatic t_stack();
        run_op(4'd1, 1'b0, 8'h5A);
        run_op(4'd1, 1'b1, 8'hA5);
        @(negedge clk); push = 1; stk_sel = 0; #1;
        chk("R10 push addr", stk_addr, 16'h01FF);
        chk("R10 push we", {15'h0, stk_we}, 16'h0001);
        chk("R10 push data", {8'h0, stk_wdata}, 16'h005A);
        @(negedge clk); idle();
        chk("R10 sp after push", sp, 16'h01FE);
        @(negedge clk); push = 1; stk_sel = 1;
        @(negedge clk); idle();
        @(negedge clk); push = 1; pop = 1; #1;
        chk("R13 no write strobe", {15'h0, stk_we}, 16'h0000);
        @(negedge clk); idle();
        chk("R13 sp held", sp, 16'h01FD);
        chk("R13 acc_a held", {8'h0, acc_a}, 16'h005A);
        @(negedge clk); pop = 1; stk_sel = 0; #1;
        chk("R11 pop addr", stk_addr, 16'h01FE);
        @(negedge clk); idle();
        chk("R11 pop into A", {8'h0, acc_a}, 16'h00A5);
        chk("R11 sp after pop", sp, 16'h01FE);
        @(negedge clk);
        pop = 1; stk_sel = 1; op_valid = 1; op_code = 4'd2; op_dst = 1;
        @(negedge clk); idle();
        chk("R11 pop beats add", {8'h0, acc_b}, 16'h005A);
        chk("R11 sp restored", sp, 16'h01FF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_incdec();
        t_ccr();
        t_stack();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule